// File: doc/BRIEF.md
# Satellite Supply Tone and Port Controller

This block turns the control bits of a dual-voltage antenna supply into the drive signals of its output stage. It divides the system clock down to a nominal 22 kHz square wave with a 50% duty cycle. It gates that tone in one of two ways: the tone either runs without a break, or it follows an asynchronous keying pin that a host processor drives to send tone-burst data. The block also decides which of the two supply ports is live. The transmit port carries both the supply and the tone. The receive port carries the supply only, through an external filter.

It further encodes the requested output level into a 2-bit code for the regulator. That code covers a low and a high supply level and an optional raise that makes up for cable loss. A thermal shutdown request from the protection logic turns every power output off, whatever the enable bit says. All outputs are registered. The keying pin passes through a two-flop synchroniser before it can gate the tone.

Top module: `sat_supply_ctrl`

## Requirements
- R1: The tone is a square wave whose period is 2*HALF clock cycles, high for HALF and low for HALF, where HALF = round(CLK_HZ / (2*TONE_HZ)). The defaults give HALF = 25.
- R2: While `toneEnBit` is 1 and the transmit port is live, the tone runs continuously, and `keyIn` has no effect on `toneOut`.
- R3: While `toneEnBit` is 0, the tone runs only while `keyIn` is high. A change on `keyIn` reaches `toneOut` three clock edges after the edge that first samples it (two synchroniser flops plus the tone register).
- R4: Each time the tone gate opens, `toneOut` starts a fresh full cycle with HALF high cycles, and the phase left over from any earlier burst plays no part. When the gate closes, `toneOut` is 0 after the next edge.
- R5: With `enBit` = 0, `powerEn`, `txPortEn`, `rxPortEn` and `toneOut` are all 0 one cycle later.
- R6: With power on, `txSelBit` = 1 gives `txPortEn` = 1 and `rxPortEn` = 0. `txSelBit` = 0 gives `rxPortEn` = 1, `txPortEn` = 0 and `toneOut` held at 0.
- R7: `voltCode` follows {`vSelBit`, `boostBit`} one cycle later, whether or not power is on. The codes are 00 = 13.25 V, 01 = 14.25 V, 10 = 18 V and 11 = 19.5 V.
- R8: `thermShut` = 1 forces `powerEn`, `txPortEn`, `rxPortEn` and `toneOut` to 0 one cycle later, even while `enBit` is 1. Operation resumes once it drops.
- R9: While `rstN` is low, every output is 0 and `voltCode` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| enBit | input | 1 | Power blocks enable |
| toneEnBit | input | 1 | Force continuous tone |
| txSelBit | input | 1 | 1 selects the transmit port, 0 the receive port |
| vSelBit | input | 1 | High supply level select |
| boostBit | input | 1 | Cable-loss raise |
| keyIn | input | 1 | Asynchronous tone keying pin |
| thermShut | input | 1 | Over-temperature shutdown request |
| toneOut | output | 1 | Gated 22 kHz tone |
| txPortEn | output | 1 | Transmit port enable |
| rxPortEn | output | 1 | Receive port enable |
| powerEn | output | 1 | Power blocks enable |
| voltCode | output | 2 | Output level code |

## Verification
The register-bit paths (`powerEn`, both port enables, `voltCode`) and the gate-closing path of the tone change after the first edge that samples a new input. A change on `keyIn` reaches `toneOut` only after the third such edge. The bench holds a behavioural model that applies exactly these delays, using a two-entry queue for the keying path and an integer phase for the tone. Inputs change on the falling edge, and every output is compared with the model on every falling edge, one half cycle after the edge that updated it.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // Output level code handed to the regulator
  typedef enum logic [1:0] {
    LVL_LOW       = 2'b00,  // 13.25 V
    LVL_LOW_RAISE = 2'b01,  // 14.25 V
    LVL_HIGH      = 2'b10,  // 18 V
    LVL_HIGH_RAISE= 2'b11   // 19.5 V
  } voltLvl_e;

  // Strobes from control to the tone datapath
  typedef struct packed {
    logic run;    // gate is open this cycle
    logic start;  // gate opened this cycle
  } toneStrb_t;

  function automatic voltLvl_e encodeLevel(input logic highSel, input logic raise);
    voltLvl_e lvl;
    case ({highSel, raise})
      2'b00:   lvl = LVL_LOW;
      2'b01:   lvl = LVL_LOW_RAISE;
      2'b10:   lvl = LVL_HIGH;
      default: lvl = LVL_HIGH_RAISE;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
  import ssc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enBit,
  input  logic      toneEnBit,
  input  logic      txSelBit,
  input  logic      vSelBit,
  input  logic      boostBit,
  input  logic      keyIn,
  input  logic      thermShut,
  output toneStrb_t strb,
  output logic      powerEn,
  output logic      txPortEn,
  output logic      rxPortEn,
  output voltLvl_e  voltCode
);

  logic [SYNC_STAGES-1:0] keySync;
  logic keySafe;
  logic powerReq;
  logic gateReq;
  logic gateOpen;
  logic gateQ;

  // Keying pin synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keySync <= '0;
    else       keySync <= {keySync[SYNC_STAGES-2:0], keyIn};
  end
  assign keySafe = keySync[SYNC_STAGES-1];

  // Thermal shutdown overrides the enable bit
  assign powerReq = enBit & ~thermShut;
  // Continuous tone wins over keying
  assign gateReq  = toneEnBit | keySafe;
  assign gateOpen = powerReq & txSelBit & gateReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= gateOpen;
  end

  always_comb begin
    strb.run   = gateOpen;
    strb.start = gateOpen & ~gateQ;
  end

  // Port steering and level code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerEn  <= 1'b0;
      txPortEn <= 1'b0;
      rxPortEn <= 1'b0;
      voltCode <= LVL_LOW;
    end else begin
      powerEn  <= powerReq;
      txPortEn <= powerReq & txSelBit;
      rxPortEn <= powerReq & ~txSelBit;
      voltCode <= encodeLevel(vSelBit, boostBit);
    end
  end

  // R8
  therm_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    thermShut |=> (!powerEn && !txPortEn && !rxPortEn));

  // R6
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !thermShut) |=> (powerEn && (txPortEn != rxPortEn)));

  // R5
  en_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> (!powerEn && !txPortEn && !rxPortEn));

endmodule

// File: rtl/ssc_tone_gen.sv
module ssc_tone_gen
  import ssc_pkg::*;
#(
  parameter int HALF_CNT = 25
) (
  input  logic      clk,
  input  logic      rstN,
  input  toneStrb_t strb,
  output logic      toneOut
);

  localparam int CNT_W = $clog2(HALF_CNT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CNT - 1);

  logic [CNT_W-1:0] halfCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      toneOut <= 1'b0;
    end else if (!strb.run) begin
      halfCnt <= '0;
      toneOut <= 1'b0;
    end else if (strb.start) begin
      halfCnt <= '0;
      toneOut <= 1'b1;
    end else if (halfCnt == LAST) begin
      halfCnt <= '0;
      toneOut <= ~toneOut;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  // R1
  half_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    halfCnt <= LAST);

  // R4
  start_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> toneOut);

  // R4
  gate_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> !toneOut);

endmodule

// File: rtl/sat_supply_ctrl.sv
module sat_supply_ctrl
  import ssc_pkg::*;
#(
  parameter int CLK_HZ      = 1_100_000,
  parameter int TONE_HZ     = 22_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enBit,
  input  logic       toneEnBit,
  input  logic       txSelBit,
  input  logic       vSelBit,
  input  logic       boostBit,
  input  logic       keyIn,
  input  logic       thermShut,
  output logic       toneOut,
  output logic       txPortEn,
  output logic       rxPortEn,
  output logic       powerEn,
  output logic [1:0] voltCode
);

  // Half period rounded to nearest integer
  localparam int HALF_CNT = (CLK_HZ + TONE_HZ) / (2 * TONE_HZ);

  toneStrb_t strb;
  voltLvl_e  lvl;

  ssc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .enBit(enBit), .toneEnBit(toneEnBit),
    .txSelBit(txSelBit), .vSelBit(vSelBit), .boostBit(boostBit),
    .keyIn(keyIn), .thermShut(thermShut), .strb(strb),
    .powerEn(powerEn), .txPortEn(txPortEn), .rxPortEn(rxPortEn),
    .voltCode(lvl)
  );

  ssc_tone_gen #(.HALF_CNT(HALF_CNT)) i_tone (
    .clk(clk), .rstN(rstN), .strb(strb), .toneOut(toneOut)
  );

  assign voltCode = lvl;

  // R6
  tone_on_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    toneOut |-> txPortEn);

endmodule

// File: tb/test_sat_supply_ctrl.sv
module test_sat_supply_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ  = 1_100_000;
  localparam int TONE_HZ = 22_000;
  localparam int H = $rtoi(real'(CLK_HZ) / (2.0 * real'(TONE_HZ)) + 0.5);

  logic clk = 0, rstN = 0;
  logic enBit = 0, toneEnBit = 0, txSelBit = 0, vSelBit = 0, boostBit = 0;
  logic keyIn = 0, thermShut = 0;
  logic toneOut, txPortEn, rxPortEn, powerEn;
  logic [1:0] voltCode;

  int checks = 0, fails = 0;
  string curReq = "R9";

  sat_supply_ctrl #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) i_sat_supply_ctrl (
    .clk(clk), .rstN(rstN), .enBit(enBit), .toneEnBit(toneEnBit),
    .txSelBit(txSelBit), .vSelBit(vSelBit), .boostBit(boostBit),
    .keyIn(keyIn), .thermShut(thermShut), .toneOut(toneOut),
    .txPortEn(txPortEn), .rxPortEn(rxPortEn), .powerEn(powerEn),
    .voltCode(voltCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int keyQ[$] = '{0, 0};
  int phase = -1;
  int expTone = 0, expTx = 0, expRx = 0, expPwr = 0, expV = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      keyQ = '{0, 0};
      phase = -1;
      expTone = 0; expTx = 0; expRx = 0; expPwr = 0; expV = 0;
    end else begin
      int pwr, gate, keyD;
      keyD = keyQ[0];
      void'(keyQ.pop_front());
      keyQ.push_back(int'(keyIn));
      pwr  = (enBit && !thermShut) ? 1 : 0;
      gate = (pwr && txSelBit && (toneEnBit || keyD != 0)) ? 1 : 0;
      if (!gate) begin
        phase = -1; expTone = 0;
      end else begin
        if (phase < 0) phase = 0;
        else phase = (phase + 1) % (2 * H);
        expTone = (phase < H) ? 1 : 0;
      end
      expPwr = pwr;
      expTx  = (pwr && txSelBit) ? 1 : 0;
      expRx  = (pwr && !txSelBit) ? 1 : 0;
      expV   = {vSelBit, boostBit};
    end
  end

  task automatic check(input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curReq, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("toneOut", int'(toneOut), expTone);
    check("txPortEn", int'(txPortEn), expTx);
    check("rxPortEn", int'(rxPortEn), expRx);
    check("powerEn", int'(powerEn), expPwr);
    check("voltCode", int'(voltCode), expV);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    // R9 reset state, with register bits already set
    curReq = "R9";
    enBit = 1; txSelBit = 1; toneEnBit = 1; vSelBit = 1; boostBit = 1;
    idle(6);
    @(negedge clk); rstN = 1;
    enBit = 0; txSelBit = 0; toneEnBit = 0; vSelBit = 0; boostBit = 0;
    idle(4);

    // R1 continuous tone, period and duty
    curReq = "R1";
    enBit = 1; txSelBit = 1; toneEnBit = 1;
    idle(6 * H);

    // R2 keying pin toggling has no effect while forced on
    curReq = "R2";
    for (int i = 0; i < 40; i++) begin
      keyIn = ~keyIn;
      idle(3 + (i % 5));
    end
    keyIn = 0;
    idle(10);

    // R3 keyed tone bursts
    curReq = "R3";
    toneEnBit = 0;
    idle(8);
    keyIn = 1; idle(5 * H);
    keyIn = 0; idle(2 * H);
    keyIn = 1; idle(H + 3);
    keyIn = 0; idle(H);
    keyIn = 1; idle(1);
    keyIn = 0; idle(10);

    // R4 restart after a short gap mid-cycle
    curReq = "R4";
    keyIn = 1; idle(H + H / 2);
    keyIn = 0; idle(2);
    keyIn = 1; idle(3 * H);
    toneEnBit = 1; keyIn = 0; idle(H / 3);
    toneEnBit = 0; idle(4);
    toneEnBit = 1; idle(2 * H);

    // R6 receive port: supply only, no tone
    curReq = "R6";
    txSelBit = 0; keyIn = 1; idle(3 * H);
    txSelBit = 1; idle(3 * H);
    toneEnBit = 0; keyIn = 0; txSelBit = 0; idle(5);

    // R7 level codes, powered and unpowered
    curReq = "R7";
    for (int i = 0; i < 8; i++) begin
      enBit = i[2];
      {vSelBit, boostBit} = 2'(i);
      idle(3);
    end
    enBit = 1;

    // R5 enable low kills everything even with tone forced
    curReq = "R5";
    txSelBit = 1; toneEnBit = 1; idle(H + 5);
    enBit = 0; idle(2 * H);
    enBit = 1; idle(H);

    // R8 thermal shutdown overrides enable
    curReq = "R8";
    thermShut = 1; idle(2 * H);
    thermShut = 0; idle(2 * H);
    txSelBit = 0; thermShut = 1; idle(5);
    thermShut = 0; idle(5);

    // R9 reset again mid-operation
    curReq = "R9";
    txSelBit = 1;
    rstN = 0; idle(4);
    rstN = 1; idle(H);

    finishRun();
  end
endmodule